// File: doc/BRIEF.md
# Baud Tick Generator with Double-Speed Option

This block produces the timing enables for a serial transmitter and receiver. A 12-bit divisor is loaded through two byte-write strobes that share one 8-bit write-data bus. The low strobe stores divisor bits 7:0 and the high strobe stores bits 11:8. A down-counting prescaler turns this divisor into an oversample tick, which the receiver uses to sample the line. A second counter divides the oversample tick by 16 to give a per-bit tick for the transmitter. When double speed is selected in asynchronous mode, that ratio is 8 instead.

A write to the low byte reloads the prescaler in the same clock edge, so the new rate starts at once. A write to the high byte only stores the upper bits. The new value takes effect at the next natural reload of the prescaler. When the transmitter starts a frame, it pulses a restart input that aligns the bit-tick phase to that frame. The divisor may be rewritten while a frame is in flight. The block does not protect the frame in that case, and the frame may be corrupted.

All pins are plain control and status pins. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 0, both readback buses read 0, and the oversample tick is high on every cycle.
- R2: A low-byte write stores wdata[7:0] in divisor bits 7:0. A high-byte write stores wdata[3:0] in divisor bits 11:8. The high readback carries divisor bits 11:8 in its bits 3:0, and its bits 7:4 always read 0.
- R3: With divisor D, the oversample tick fires once every D+1 cycles. When D > 0, each tick lasts exactly one cycle.
- R4: A low-byte write reloads the prescaler with the new full divisor at that clock edge. The first oversample tick then appears exactly D cycles after the write cycle.
- R5: A high-byte write does not reload the prescaler. The count already in progress runs out unchanged, and the new value is used from the next reload onward.
- R6: In normal mode the bit tick fires on every 16th oversample tick, and it is only ever high together with an oversample tick.
- R7: When double speed is set and asynchronous mode is selected, the bit tick fires on every 8th oversample tick. When asynchronous mode is not selected, double speed has no effect and the ratio stays 16.
- R8: A one-cycle frame-start pulse restarts the bit phase. Oversample ticks are counted from the cycle after the pulse, and the first bit tick comes on the 16th of them, or the 8th in double speed. No bit tick is produced in the cycle of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_lo_we | input | 1 | Write strobe for divisor bits 7:0; reloads the prescaler |
| div_hi_we | input | 1 | Write strobe for divisor bits 11:8 |
| wdata | input | 8 | Write data shared by both strobes |
| dbl_speed | input | 1 | Double-speed select (bit ratio 8) |
| mode_async | input | 1 | High when asynchronous mode is selected; double speed is honoured only then |
| frame_start | input | 1 | Restarts the bit-tick phase |
| div_lo_rd | output | 8 | Readback of divisor bits 7:0 |
| div_hi_rd | output | 8 | Readback of divisor bits 11:8, with bits 7:4 always 0 |
| os_tick | output | 1 | Oversample tick, once every divisor+1 cycles |
| bit_tick | output | 1 | Per-bit tick |

## Verification
The hardest case to reach is a high-byte write that lands in the middle of a count. From the ports, its effect cannot be told apart from an immediate reload unless the prescaler timing is observed across two tick periods. The stimulus first reloads with a low-byte write, waits a few cycles, and then writes the high byte. It then checks two intervals: the first tick must still arrive at the old distance, and the following period must use the combined new divisor. Frame-start restarts are applied at arbitrary oversample phases, so the bit phase is shown to depend only on the restart.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    RATIO_NORMAL = 1'b0,
    RATIO_DOUBLE = 1'b1
  } ratio_sel_e;
endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int DIV_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_next,
  output logic [BYTE_W-1:0] rd_lo,
  output logic [BYTE_W-1:0] rd_hi
);
  localparam int HI_W = DIV_W - BYTE_W;

  // Combined value seen by the prescaler on a low-byte write this cycle.
  always_comb begin
    div_next = div_q;
    if (lo_we) div_next[BYTE_W-1:0] = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      if (lo_we) div_q[BYTE_W-1:0] <= wdata;
      if (hi_we) div_q[DIV_W-1:BYTE_W] <= wdata[HI_W-1:0];
    end
  end

  assign rd_lo = div_q[BYTE_W-1:0];
  assign rd_hi = {{(BYTE_W-HI_W){1'b0}}, div_q[DIV_W-1:BYTE_W]};

  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we && !lo_we |=> div_q[BYTE_W-1:0] == $past(div_q[BYTE_W-1:0])); // R2
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we && !hi_we |=> div_q[DIV_W-1:BYTE_W] == $past(div_q[DIV_W-1:BYTE_W])); // R2
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] reload_val,
  output logic             os_tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load_en)           cnt_q <= load_val;
    else if (cnt_q == '0)       cnt_q <= reload_val;
    else                        cnt_q <= cnt_q - 1'b1;
  end

  assign os_tick = (cnt_q == '0);

  AST_IMMEDIATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == $past(load_val)); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !os_tick |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick && !load_en && reload_val != '0 |=> !os_tick); // R3
endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter
  import baud_pkg::*;
#(
  parameter int OS_RATIO  = 16,
  parameter int DBL_RATIO = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ratio_sel_e ratio_sel,
  input  logic       restart,
  input  logic       os_tick,
  output logic       bit_tick
);
  localparam int SUB_W = $clog2(OS_RATIO);
  localparam logic [SUB_W-1:0] NORM_LAST = SUB_W'(OS_RATIO - 1);
  localparam logic [SUB_W-1:0] DBL_LAST  = SUB_W'(DBL_RATIO - 1);

  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] last_idx;
  logic             at_last;

  assign last_idx = (ratio_sel == RATIO_DOUBLE) ? DBL_LAST : NORM_LAST;
  assign at_last  = (sub_q >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)         sub_q <= '0;
    else if (restart)   sub_q <= '0;
    else if (os_tick)   sub_q <= at_last ? '0 : sub_q + 1'b1;
  end

  assign bit_tick = os_tick && at_last && !restart;

  AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> sub_q == '0); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !restart && !os_tick |=> $stable(sub_q)); // R6
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W     = 12,
  parameter int BYTE_W    = 8,
  parameter int OS_RATIO  = 16,
  parameter int DBL_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_lo_we,
  input  logic              div_hi_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              dbl_speed,
  input  logic              mode_async,
  input  logic              frame_start,
  output logic [BYTE_W-1:0] div_lo_rd,
  output logic [BYTE_W-1:0] div_hi_rd,
  output logic              os_tick,
  output logic              bit_tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  ratio_sel_e       ratio_sel;

  assign ratio_sel = (dbl_speed && mode_async) ? RATIO_DOUBLE : RATIO_NORMAL;

  baud_div_reg #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .lo_we(div_lo_we), .hi_we(div_hi_we),
    .wdata(wdata), .div_q(div_q), .div_next(div_next),
    .rd_lo(div_lo_rd), .rd_hi(div_hi_rd)
  );

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load_en(div_lo_we), .load_val(div_next),
    .reload_val(div_q), .os_tick(os_tick)
  );

  baud_bit_counter #(.OS_RATIO(OS_RATIO), .DBL_RATIO(DBL_RATIO)) u_bit (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .restart(frame_start),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  AST_HI_RD_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    div_hi_we |=> div_hi_rd[BYTE_W-1:DIV_W-BYTE_W] == '0); // R2
  AST_NO_BIT_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !bit_tick); // R8
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_lo_we = 1'b0, div_hi_we = 1'b0;
  logic [7:0] wdata = '0;
  logic dbl_speed = 1'b0, mode_async = 1'b1, frame_start = 1'b0;
  logic [7:0] div_lo_rd, div_hi_rd;
  logic os_tick, bit_tick;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
    .wdata(wdata), .dbl_speed(dbl_speed), .mode_async(mode_async),
    .frame_start(frame_start), .div_lo_rd(div_lo_rd), .div_hi_rd(div_hi_rd),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_lo(input logic [7:0] v);
    wdata = v; div_lo_we = 1'b1; step(); div_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] v);
    wdata = v; div_hi_we = 1'b1; step(); div_hi_we = 1'b0;
  endtask

  // cycles until os_tick is seen, starting with the current cycle
  task automatic wait_tick(output int k);
    k = 0;
    while (!os_tick && k < 5000) begin step(); k++; end
  endtask

  task automatic test_reset();
    int n = 0;
    check("R1 lo_rd", div_lo_rd, 0);
    check("R1 hi_rd", div_hi_rd, 0);
    for (int i = 0; i < 4; i++) begin n += os_tick; step(); end
    check("R1 os_tick every cycle", n, 4);
  endtask

  task automatic test_regs();
    wr_hi(8'hFA);
    check("R2 hi_rd reserved zero", div_hi_rd, 8'h0A);
    wr_lo(8'h5C);
    check("R2 lo_rd", div_lo_rd, 8'h5C);
    check("R2 hi kept", div_hi_rd, 8'h0A);
    wr_hi(8'h00);
    check("R2 hi cleared", div_hi_rd, 0);
    check("R2 lo kept", div_lo_rd, 8'h5C);
  endtask

  task automatic test_period(input logic [7:0] d);
    int k;
    wr_lo(d);
    wait_tick(k);
    check("R4 first tick after low write", k, d);
    step();
    if (d != 0) check("R3 tick one cycle", os_tick, 0);
    wait_tick(k);
    check("R3 period", k + 1, d + 1);
  endtask

  task automatic test_hi_no_reload();
    int k;
    wr_lo(8'd20);
    for (int i = 0; i < 5; i++) step();
    wr_hi(8'h01);
    wait_tick(k);
    check("R5 count unaffected by high write", k + 6, 20);
    step();
    wait_tick(k);
    check("R5 new period after reload", k + 1, 277);
    wr_hi(8'h00);
  endtask

  task automatic test_bits(input logic dbl, input logic asy, input int ratio,
                           input string req);
    int n = 0, k, stray = 0;
    dbl_speed = dbl; mode_async = asy;
    wr_lo(8'd3);
    step(); step();
    frame_start = 1'b1;
    check("R8 no bit tick on restart", bit_tick, 0);
    step(); frame_start = 1'b0;
    for (int j = 0; j < 2; j++) begin
      n = 0; k = 0;
      while (k < 2000) begin
        if (bit_tick && !os_tick) stray++;
        if (os_tick) begin
          n++;
          if (bit_tick) break;
        end
        step(); k++;
      end
      check(req, n, ratio);
      step();
    end
    check("R6 bit tick only with os tick", stray, 0);
    dbl_speed = 1'b0; mode_async = 1'b1;
  endtask

  initial begin
    fork
      begin
        step(); step(); rst_n = 1'b1;
        test_reset();
        test_regs();
        test_period(8'd0);
        test_period(8'd1);
        test_period(8'd7);
        test_period(8'd37);
        test_hi_no_reload();
        test_bits(1'b0, 1'b1, 16, "R6 normal ratio");
        test_bits(1'b1, 1'b1, 8,  "R7 double speed async");
        test_bits(1'b1, 1'b0, 16, "R7 double ignored when not async");
        test_bits(1'b0, 1'b1, 16, "R8 restart alignment");
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule